// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block holds the time of day and the calendar as packed BCD digits: seconds, minutes, hours, day of month, month, a two-digit year and a day-of-week count. Each one-second enable pulse moves the count forward by one second. Carries ripple through minutes, hours, days, months and years in the same cycle. Month lengths and leap years are worked out internally from the stored month and year.

A host loads any digit register through a single-cycle write port and reads any digit through a combinational read port. The hour can be counted in 24-hour form or in 12-hour form with a PM flag, chosen by a mode input. The block does not reject a day of month that is too large for its month. Such a day is kept until the next day carry, which then moves the date to the 1st of the following month.

Top module: `bcd_calendar_clock`

## Requirements
- R1: Seconds and minutes each count 00 to 59 in BCD. A tick at 59 seconds gives 00 and carries into the minutes, and 59 minutes with a seconds carry gives 00 and carries into the hours.
- R2: With `hour24` high, hours run 00 to 23, and 23 with a minute carry gives 00 plus a day carry. Tens-of-hours bit 1 means 20 and bit 0 means 10. A PM bit written in this mode is dropped, and PM always reads back as 0.
- R3: With `hour24` low, hours run 12, 01, 02 up to 11. The PM bit (bit 2 of the hour-tens register) flips when 11 goes to 12. A day carry happens only on the step from 11 PM to 12 AM.
- R4: The day advances up to the length of its month and then returns to 01 with a month increment. April, June, September and November have 30 days, February has 28 or 29, and the other months have 31.
- R5: February has 29 days when the two-digit year is a multiple of 4, including year 00. Otherwise it has 28.
- R6: A day written beyond its month's length is held unchanged until the next day carry. That carry then produces day 01 of the next month.
- R7: Month 12 with a day-of-month carry gives month 01 and a year increment, and year 99 goes to 00.
- R8: The weekday register counts 0 (Sunday) to 6 (Saturday). Every day carry advances it, and 6 wraps to 0.
- R9: The register map for reads and writes is: 0 seconds units, 1 seconds tens (3 bits), 2 minutes units, 3 minutes tens (3 bits), 4 hours units, 5 hours tens {PM, tens-20, tens-10}, 6 day units, 7 day tens (2 bits), 8 month units, 9 month tens (1 bit), 10 year units, 11 year tens, 12 weekday (3 bits). Addresses 13 to 15 read 0 and ignore writes, and bits beyond a field's width read 0. After reset the count is 00:00:00, day 01, month 01, year 00, weekday 0.
- R10: A write loads its digit at the next clock edge. A tick that arrives in the same cycle as any write is discarded.
- R11: In a cycle with no tick and no write, every register keeps its value.
- R12: With `hour24` low, the tens-20 bit of the hour register reads back the last value written, and the hour advance clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle pulse that advances the count by one second |
| hour24 | input | 1 | 1 selects 24-hour counting, 0 selects 12-hour counting with PM |
| wrEn | input | 1 | Write strobe for the digit selected by wrAddr |
| wrAddr | input | 4 | Register index for writes |
| wrData | input | 4 | Digit value to write |
| rdAddr | input | 4 | Register index for reads |
| rdData | output | 4 | Selected digit, valid in the same cycle |

## Verification
The properties are checked on every cycle. They cover: seconds clearing after a seconds carry, the day returning to 01 after a month-end carry, weekday wrap, year wrap from 99, the PM flip at 11 in 12-hour mode, the PM bit being dropped on a 24-hour write, a write overriding the seconds, and every register holding still when nothing happens. Some behaviour can only be shown by the bench's scenarios against its own calendar model. This includes the full carry ripple from 23:59:59 on 31 December 99, the leap-year February lengths, the correction of a written day that is out of range, the read-back masking of unused bits and addresses, and long runs of ticks from random boundary-heavy start times.

// File: rtl/calClkPkg.sv
package calClkPkg;
  localparam int DIG_W  = 4;
  localparam int ADDR_W = 4;
  localparam int BIN_W  = 7;

  localparam logic [ADDR_W-1:0] A_SECU = 4'd0;
  localparam logic [ADDR_W-1:0] A_SECT = 4'd1;
  localparam logic [ADDR_W-1:0] A_MINU = 4'd2;
  localparam logic [ADDR_W-1:0] A_MINT = 4'd3;
  localparam logic [ADDR_W-1:0] A_HRU  = 4'd4;
  localparam logic [ADDR_W-1:0] A_HRT  = 4'd5;
  localparam logic [ADDR_W-1:0] A_DAYU = 4'd6;
  localparam logic [ADDR_W-1:0] A_DAYT = 4'd7;
  localparam logic [ADDR_W-1:0] A_MONU = 4'd8;
  localparam logic [ADDR_W-1:0] A_MONT = 4'd9;
  localparam logic [ADDR_W-1:0] A_YRU  = 4'd10;
  localparam logic [ADDR_W-1:0] A_YRT  = 4'd11;
  localparam logic [ADDR_W-1:0] A_WDAY = 4'd12;

  // Stored calendar state, each field only as wide as its digit needs.
  typedef struct packed {
    logic [DIG_W-1:0] secU;
    logic [2:0]       secT;
    logic [DIG_W-1:0] minU;
    logic [2:0]       minT;
    logic [DIG_W-1:0] hrU;
    logic [2:0]       hrT;   // {pm, tens20, tens10}
    logic [DIG_W-1:0] dayU;
    logic [1:0]       dayT;
    logic [DIG_W-1:0] monU;
    logic [0:0]       monT;
    logic [DIG_W-1:0] yrU;
    logic [DIG_W-1:0] yrT;
    logic [2:0]       wday;
  } calTime_t;

  // Carry strobes from control to datapath.
  typedef struct packed {
    logic tick;
    logic secCarry;
    logic minCarry;
    logic dayCarry;
    logic monCarry;
    logic yrCarry;
    logic wdWrap;
  } calStrb_t;

  function automatic logic [BIN_W-1:0] toBin(input logic [DIG_W-1:0] tens,
                                             input logic [DIG_W-1:0] units);
    return BIN_W'(tens) * BIN_W'(10) + BIN_W'(units);
  endfunction

  function automatic logic [2*DIG_W-1:0] toBcd(input logic [BIN_W-1:0] v);
    logic [BIN_W-1:0] q;
    q = v / BIN_W'(10);
    return {DIG_W'(q), DIG_W'(v - q * BIN_W'(10))};
  endfunction

  function automatic logic [BIN_W-1:0] monthDays(input logic [BIN_W-1:0] mon,
                                                 input logic [BIN_W-1:0] yr);
    logic leap;
    leap = (yr[1:0] == 2'b00);
    case (mon)
      BIN_W'(2):  return leap ? BIN_W'(29) : BIN_W'(28);
      BIN_W'(4), BIN_W'(6), BIN_W'(9), BIN_W'(11): return BIN_W'(30);
      default:    return BIN_W'(31);
    endcase
  endfunction
endpackage

// File: rtl/calClkCtrl.sv
module calClkCtrl
  import calClkPkg::*;
(
  input  logic     tickEn,
  input  logic     wrEn,
  input  logic     hour24,
  input  calTime_t cur,
  output calStrb_t strb
);
  logic [BIN_W-1:0] secBin, minBin, hr24Bin, hr12Bin, dayBin, monBin, yrBin;
  logic             hourWrap;

  always_comb begin
    secBin  = toBin({1'b0, cur.secT}, cur.secU);
    minBin  = toBin({1'b0, cur.minT}, cur.minU);
    hr24Bin = toBin({2'b00, cur.hrT[1:0]}, cur.hrU);
    hr12Bin = toBin({3'b000, cur.hrT[0]}, cur.hrU);
    dayBin  = toBin({2'b00, cur.dayT}, cur.dayU);
    monBin  = toBin({3'b000, cur.monT}, cur.monU);
    yrBin   = toBin(cur.yrT, cur.yrU);
  end

  // 24h: rollover after 23. 12h: rollover only leaving 11 PM.
  assign hourWrap = hour24 ? (hr24Bin >= BIN_W'(23))
                           : ((hr12Bin == BIN_W'(11)) && cur.hrT[2]);

  always_comb begin
    strb.tick     = tickEn & ~wrEn;
    strb.secCarry = strb.tick & (secBin >= BIN_W'(59));
    strb.minCarry = strb.secCarry & (minBin >= BIN_W'(59));
    strb.dayCarry = strb.minCarry & hourWrap;
    // >= rather than == so that an oversized written day folds into the next month
    strb.monCarry = strb.dayCarry & (dayBin >= monthDays(monBin, yrBin));
    strb.yrCarry  = strb.monCarry & (monBin >= BIN_W'(12));
    strb.wdWrap   = strb.dayCarry & (cur.wday >= 3'd6);
  end
endmodule

// File: rtl/calClkDatapath.sv
module calClkDatapath
  import calClkPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hour24,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DIG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  calStrb_t          strb,
  output calTime_t          cur,
  output logic [DIG_W-1:0]  rdData
);
  calTime_t         tm;
  logic [BIN_W-1:0] secBin, minBin, hr24Bin, hr12Bin, dayBin, monBin, yrBin;
  logic [BIN_W-1:0] hrNextBin;
  logic [2*DIG_W-1:0] secN, minN, hrN, dayN, monN, yrN;
  logic [2:0]       hrTNext;
  logic             pmNext;
  logic [2:0]       wdNext;

  assign cur = tm;

  always_comb begin
    secBin  = toBin({1'b0, tm.secT}, tm.secU);
    minBin  = toBin({1'b0, tm.minT}, tm.minU);
    hr24Bin = toBin({2'b00, tm.hrT[1:0]}, tm.hrU);
    hr12Bin = toBin({3'b000, tm.hrT[0]}, tm.hrU);
    dayBin  = toBin({2'b00, tm.dayT}, tm.dayU);
    monBin  = toBin({3'b000, tm.monT}, tm.monU);
    yrBin   = toBin(tm.yrT, tm.yrU);

    secN = toBcd(strb.secCarry ? '0 : secBin + BIN_W'(1));
    minN = toBcd(strb.minCarry ? '0 : minBin + BIN_W'(1));
    dayN = toBcd(strb.monCarry ? BIN_W'(1) : dayBin + BIN_W'(1));
    monN = toBcd(strb.yrCarry ? BIN_W'(1) : monBin + BIN_W'(1));
    yrN  = toBcd((yrBin >= BIN_W'(99)) ? '0 : yrBin + BIN_W'(1));
    wdNext = strb.wdWrap ? 3'd0 : tm.wday + 3'd1;

    pmNext = 1'b0;
    if (hour24) begin
      hrNextBin = (hr24Bin >= BIN_W'(23)) ? '0 : hr24Bin + BIN_W'(1);
    end else begin
      pmNext = tm.hrT[2];
      if (hr12Bin == BIN_W'(11)) begin
        hrNextBin = BIN_W'(12);
        pmNext    = ~tm.hrT[2];
      end else if (hr12Bin >= BIN_W'(12)) begin
        hrNextBin = BIN_W'(1);
      end else begin
        hrNextBin = hr12Bin + BIN_W'(1);
      end
    end
    hrN = toBcd(hrNextBin);
    if (hour24) hrTNext = {1'b0, hrN[7:4] == 4'd2, hrN[7:4] == 4'd1};
    else        hrTNext = {pmNext, 1'b0, hrN[7:4] == 4'd1};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tm      <= '0;
      tm.dayU <= 4'd1;
      tm.monU <= 4'd1;
    end else if (wrEn) begin
      case (wrAddr)
        A_SECU: tm.secU <= wrData;
        A_SECT: tm.secT <= wrData[2:0];
        A_MINU: tm.minU <= wrData;
        A_MINT: tm.minT <= wrData[2:0];
        A_HRU:  tm.hrU  <= wrData;
        A_HRT:  tm.hrT  <= {wrData[2] & ~hour24, wrData[1:0]};
        A_DAYU: tm.dayU <= wrData;
        A_DAYT: tm.dayT <= wrData[1:0];
        A_MONU: tm.monU <= wrData;
        A_MONT: tm.monT <= wrData[0];
        A_YRU:  tm.yrU  <= wrData;
        A_YRT:  tm.yrT  <= wrData;
        A_WDAY: tm.wday <= wrData[2:0];
        default: ;
      endcase
    end else if (strb.tick) begin
      {tm.secT, tm.secU} <= {secN[6:4], secN[3:0]};
      if (strb.secCarry) {tm.minT, tm.minU} <= {minN[6:4], minN[3:0]};
      if (strb.minCarry) {tm.hrT, tm.hrU} <= {hrTNext, hrN[3:0]};
      if (strb.dayCarry) begin
        {tm.dayT, tm.dayU} <= {dayN[5:4], dayN[3:0]};
        tm.wday <= wdNext;
      end
      if (strb.monCarry) {tm.monT, tm.monU} <= {monN[4], monN[3:0]};
      if (strb.yrCarry)  {tm.yrT, tm.yrU}   <= yrN;
    end
  end

  always_comb begin
    case (rdAddr)
      A_SECU:  rdData = tm.secU;
      A_SECT:  rdData = {1'b0, tm.secT};
      A_MINU:  rdData = tm.minU;
      A_MINT:  rdData = {1'b0, tm.minT};
      A_HRU:   rdData = tm.hrU;
      A_HRT:   rdData = {1'b0, tm.hrT[2] & ~hour24, tm.hrT[1:0]};
      A_DAYU:  rdData = tm.dayU;
      A_DAYT:  rdData = {2'b00, tm.dayT};
      A_MONU:  rdData = tm.monU;
      A_MONT:  rdData = {3'b000, tm.monT};
      A_YRU:   rdData = tm.yrU;
      A_YRT:   rdData = tm.yrT;
      A_WDAY:  rdData = {1'b0, tm.wday};
      default: rdData = '0;
    endcase
  end

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.secCarry |=> (tm.secU == 4'd0 && tm.secT == 3'd0)); // R1

  AST_PM_DROPPED_24H: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_HRT && hour24) |=> !tm.hrT[2]); // R2

  AST_PM_FLIP_AT_11: assert property (@(posedge clk) disable iff (!rstN)
    (!hour24 && strb.minCarry && hr12Bin == BIN_W'(11)) |=> (tm.hrT[2] != $past(tm.hrT[2]))); // R3

  AST_MONTH_END_DAY1: assert property (@(posedge clk) disable iff (!rstN)
    strb.monCarry |=> (tm.dayU == 4'd1 && tm.dayT == 2'd0)); // R4

  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.yrCarry && yrBin == BIN_W'(99)) |=> (tm.yrU == 4'd0 && tm.yrT == 4'd0)); // R7

  AST_WEEK_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.wdWrap |=> (tm.wday == 3'd0)); // R8

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_SECU) |=> (tm.secU == $past(wrData))); // R10
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import calClkPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              hour24,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DIG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DIG_W-1:0]  rdData
);
  calTime_t cur;
  calStrb_t strb;

  calClkCtrl u_ctrl (
    .tickEn (tickEn),
    .wrEn   (wrEn),
    .hour24 (hour24),
    .cur    (cur),
    .strb   (strb)
  );

  calClkDatapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .hour24 (hour24),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .strb   (strb),
    .cur    (cur),
    .rdData (rdData)
  );

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !wrEn) |=> $stable(cur)); // R11
endmodule

// File: tb/bcd_calendar_clock_bench.sv
module bcd_calendar_clock_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       hour24 = 1'b1;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [3:0] wrData = '0;
  logic [3:0] rdAddr = '0;
  logic [3:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench calendar model
  int mSec, mMin, mHr, mDay, mMon, mYr, mWd;
  bit mPm, mH20;

  always #4 clk = ~clk;

  bcd_calendar_clock u_bcd_calendar_clock (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .hour24(hour24),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  function automatic int dim(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [3:0] expDigit(int a);
    case (a)
      0:  return 4'(mSec % 10);
      1:  return 4'(mSec / 10);
      2:  return 4'(mMin % 10);
      3:  return 4'(mMin / 10);
      4:  return 4'(mHr % 10);
      5:  if (hour24) return {2'b00, mHr >= 20, mHr >= 10 && mHr < 20};
          else        return {1'b0, mPm, mH20, mHr >= 10};
      6:  return 4'(mDay % 10);
      7:  return 4'(mDay / 10);
      8:  return 4'(mMon % 10);
      9:  return 4'(mMon / 10);
      10: return 4'(mYr % 10);
      11: return 4'(mYr / 10);
      12: return 4'(mWd);
      default: return 4'd0;
    endcase
  endfunction

  task automatic dayAdvance();
    mWd = (mWd >= 6) ? 0 : mWd + 1;
    if (mDay >= dim(mMon, mYr)) begin
      mDay = 1;
      if (mMon >= 12) begin
        mMon = 1;
        mYr = (mYr >= 99) ? 0 : mYr + 1;
      end else mMon++;
    end else mDay++;
  endtask

  task automatic modelTick();
    if (mSec < 59) begin mSec++; return; end
    mSec = 0;
    if (mMin < 59) begin mMin++; return; end
    mMin = 0;
    mH20 = 0;
    if (hour24) begin
      if (mHr >= 23) begin mHr = 0; dayAdvance(); end
      else mHr++;
    end else begin
      if (mHr == 11) begin
        mHr = 12;
        if (mPm) begin mPm = 0; dayAdvance(); end
        else mPm = 1;
      end else if (mHr >= 12) mHr = 1;
      else mHr++;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setAll(int hr, bit pm, int mi, int s, int d, int mo, int y, int wd);
    mHr = hr; mPm = hour24 ? 1'b0 : pm; mH20 = 0; mMin = mi; mSec = s;
    mDay = d; mMon = mo; mYr = y; mWd = wd;
    for (int a = 0; a < 13; a++) wr(4'(a), expDigit(a));
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1;
      @(negedge clk);
      modelTick();
    end
    tickEn = 1'b0;
  endtask

  task automatic cmp(string req, int a, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s reg %0d got %h expected %h", req, a, got, exp);
    end
  endtask

  task automatic checkAll(string req);
    for (int a = 0; a < 16; a++) begin
      rdAddr = 4'(a);
      #1;
      cmp(req, a, rdData, expDigit(a));
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mSec = 0; mMin = 0; mHr = 0; mDay = 1; mMon = 1; mYr = 0; mWd = 0; mPm = 0; mH20 = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R9 reset");

    // R1 R2 R4 R7 R8: full ripple from 23:59:58 on 31 Dec 99, Saturday
    hour24 = 1'b1;
    setAll(23, 0, 59, 58, 31, 12, 99, 6);
    ticks(1);
    checkAll("R1");
    ticks(1);
    checkAll("R7 R8 R2 ripple");

    // R4: 30-day month end
    setAll(23, 0, 59, 59, 30, 4, 10, 2);
    ticks(1);
    checkAll("R4");

    // R5: leap and non-leap February, year 00 leap
    setAll(23, 0, 59, 59, 28, 2, 24, 3);
    ticks(1);
    checkAll("R5 leap 28->29");
    ticks(86400 / 86400);
    setAll(23, 0, 59, 59, 28, 2, 23, 3);
    ticks(1);
    checkAll("R5 nonleap");
    setAll(23, 0, 59, 59, 29, 2, 0, 1);
    ticks(1);
    checkAll("R5 year00");

    // R6: oversized day folds into next month on carry
    setAll(10, 0, 20, 0, 30, 2, 23, 0);
    ticks(3);
    checkAll("R6 held");
    setAll(23, 0, 59, 59, 30, 2, 23, 0);
    ticks(1);
    checkAll("R6 feb30");
    setAll(23, 0, 59, 59, 31, 11, 85, 4);
    ticks(1);
    checkAll("R6 nov31");

    // R2: PM bit dropped in 24h mode
    setAll(14, 0, 0, 0, 5, 5, 5, 5);
    wr(4'd5, 4'b0101);
    mHr = 14;
    checkAll("R2 pm dropped");

    // R3: 12h sequence
    hour24 = 1'b0;
    setAll(11, 0, 59, 59, 15, 6, 30, 2);
    ticks(1);
    checkAll("R3 11am->12pm");
    setAll(12, 1, 59, 59, 15, 6, 30, 2);
    ticks(1);
    checkAll("R3 12->1");
    setAll(11, 1, 59, 59, 30, 6, 30, 2);
    ticks(1);
    checkAll("R3 11pm->12am");

    // R12: tens-20 bit readback in 12h mode, then cleared by advance
    setAll(9, 0, 59, 50, 1, 1, 1, 1);
    wr(4'd5, 4'b0010);
    mH20 = 1;
    checkAll("R12 h20 set");
    wr(4'd5, 4'b0000);
    mH20 = 0;
    checkAll("R12 h20 clear");
    wr(4'd5, 4'b0010);
    mH20 = 1;
    ticks(10);
    checkAll("R12 h20 advance");

    // R10: coincident tick and write
    hour24 = 1'b1;
    setAll(1, 0, 2, 10, 3, 3, 3, 3);
    tickEn = 1'b1;
    wr(4'd0, 4'd5);
    tickEn = 1'b0;
    mSec = 15;
    checkAll("R10 write wins");

    // R11: idle
    repeat (20) @(negedge clk);
    checkAll("R11 idle");

    // R9: write to unused address
    wr(4'd14, 4'hF);
    wr(4'd13, 4'h7);
    checkAll("R9 unused addr");

    // random boundary-heavy runs
    for (int it = 0; it < 40; it++) begin
      int mo, y;
      hour24 = 1'($urandom % 2);
      mo = 1 + int'($urandom % 12);
      y  = int'($urandom % 100);
      setAll(hour24 ? int'($urandom % 24) : 1 + int'($urandom % 12),
             1'($urandom % 2),
             ($urandom % 2) ? 59 : int'($urandom % 60),
             50 + int'($urandom % 10),
             ($urandom % 2) ? dim(mo, y) : 1 + int'($urandom % dim(mo, y)),
             mo, y, int'($urandom % 7));
      ticks(1 + int'($urandom % 200));
      checkAll(hour24 ? "R1 R2 R4 random" : "R3 R4 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule